// File: doc/BRIEF.md
# Dual-Slice Data Integrity Checker

This block sits at the receive end of a test data path. It takes the decoded data words and checks each one against an expected copy that it builds itself from the same pseudo-random sequence the traffic source uses. It counts how many words matched and how many differed. The counts are kept separately for two slices, A and B.

The block runs in one of two modes, picked at runtime. In combined mode the full 320-bit bus is one word stream, and only the slice A counters move. In split mode the bus carries two independent 160-bit streams. The lower half belongs to slice A and the upper half to slice B. Each slice has its own valid and start-of-codeword flags, its own expected-data generator and its own pair of counters.

Each expected-data generator waits for a start-of-codeword after a reset or a clear before it counts anything. This lines the generator up with the incoming stream.

Top module: `dic_checker`

## Requirements
- R1: Combined mode (`combined_mode`=1): a counted slice A beat compares all 320 bits of `rx_data` against the expected word. The lower 160 bits of that word are the slice A lane word. Bits 319:160 are five copies of {1'b0, ~s}. Only the A counters record the result.
- R2: Split mode (`combined_mode`=0): slice A compares `rx_data[159:0]` and slice B compares `rx_data[319:160]`. Each slice uses its own generator, valid, start flag and counters, and neither slice affects the other.
- R3: While `combined_mode`=1, the B counters do not change, whatever the B inputs are. After a clear they therefore stay at zero.
- R4: Every counted beat increments exactly one counter of its slice. The match counter moves when the word equals the expected word. The mismatch counter moves when any bit differs.
- R5: Expected data comes from a 31-bit LFSR, x^31+x^28+1, with next state {s[29:0], s[30]^s[27]}. The seed is parameter SEED, default 1. A lane word is five copies of {1'b1, s}. The LFSR steps once per counted beat only; idle cycles leave it unchanged.
- R6: After a reset or a clear, beats are ignored until the first valid beat that has its start flag set. That beat is compared against the seed word. Later start flags do not restart the sequence.
- R7: Counters are CNT_W bits wide (default 32). They hold at all ones instead of wrapping.
- R8: A `clr` pulse zeroes all four counters and un-aligns both generators on the next edge. A beat in the same cycle as the clear is not counted.
- R9: After reset, all four counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| combined_mode | input | 1 | 1 = one 320-bit stream, 0 = two 160-bit streams |
| clr | input | 1 | Synchronous clear of counters and alignment |
| rx_data | input | 320 | Received decoded data |
| rx_valid_a | input | 1 | Slice A beat valid (the whole bus in combined mode) |
| rx_sop_a | input | 1 | Slice A start of codeword |
| rx_valid_b | input | 1 | Slice B beat valid (ignored in combined mode) |
| rx_sop_b | input | 1 | Slice B start of codeword |
| a_match_cnt | output | CNT_W | Slice A matched words |
| a_miss_cnt | output | CNT_W | Slice A mismatched words |
| b_match_cnt | output | CNT_W | Slice B matched words |
| b_miss_cnt | output | CNT_W | Slice B mismatched words |

## Verification
The assertions check four things on every cycle:
- the B counters stay frozen in combined mode;
- a start beat moves exactly one A counter;
- the counters saturate, step by one and clear;
- alignment is only gained on a valid start beat.

Whether a given word is judged equal depends on the LFSR sequence and the lane layout. Only the bench's scenarios can show this, as they drive known-good and bit-flipped words. The same holds for alignment that is held across later start flags, for gaps in valid, and for two slices that are aligned at different times.

// File: rtl/dic_pkg.sv
// Shared types for the data integrity checker.
// Assumes a 31-bit Fibonacci LFSR, x^31 + x^28 + 1.
package dic_pkg;
    localparam int LFSR_W = 31;
    typedef logic [LFSR_W-1:0] lfsr_t;

    // One step of the expected-data sequence.
    function automatic lfsr_t lfsr_next(lfsr_t s);
        return {s[LFSR_W-2:0], s[30] ^ s[27]};
    endfunction
endpackage

// File: rtl/dic_lane_gen.sv
// Expected-data generator for one slice.
// It holds the LFSR state and the alignment flag, and reports which beats count.
// Assumes beat_vld has already been gated by the mode where that is needed.
module dic_lane_gen
    import dic_pkg::*;
#(
    parameter lfsr_t SEED = 31'h1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  beat_vld,
    input  logic  beat_sop,
    output logic  hit,
    output lfsr_t exp_state
);
    logic  aligned;
    lfsr_t state_q;

    // State used for the current beat: the seed while still unaligned.
    assign exp_state = aligned ? state_q : SEED;

    // A beat counts once aligned, or when it is itself the aligning start beat.
    assign hit = beat_vld && (aligned || beat_sop) && !clr;

    // Track alignment and step the sequence on counted beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aligned <= 1'b0;
            state_q <= SEED;
        end else if (clr) begin
            aligned <= 1'b0;
        end else if (hit) begin
            aligned <= 1'b1;
            state_q <= lfsr_next(exp_state);
        end
    end

    // R6
    align_on_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned) |-> $past(beat_vld && beat_sop && !clr));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned && !beat_vld && !clr) |=> $stable(state_q));
endmodule

// File: rtl/dic_sat_cnt.sv
// Saturating event counter with synchronous clear.
// Clear takes priority over an increment in the same cycle.
module dic_sat_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count up, hold at the maximum, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);

    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);

    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/dic_checker.sv
// Dual-slice data integrity checker top level.
// Compares received words against regenerated LFSR data and counts the
// matches and mismatches per slice. Combined mode uses the whole bus for
// slice A; split mode gives each slice one half.
// Assumes LANE_W is a multiple of 32.
module dic_checker
    import dic_pkg::*;
#(
    parameter int    LANE_W = 160,
    parameter int    CNT_W  = 32,
    parameter lfsr_t SEED   = 31'h1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                combined_mode,
    input  logic                clr,
    input  logic [2*LANE_W-1:0] rx_data,
    input  logic                rx_valid_a,
    input  logic                rx_sop_a,
    input  logic                rx_valid_b,
    input  logic                rx_sop_b,
    output logic [CNT_W-1:0]    a_match_cnt,
    output logic [CNT_W-1:0]    a_miss_cnt,
    output logic [CNT_W-1:0]    b_match_cnt,
    output logic [CNT_W-1:0]    b_miss_cnt
);
    localparam int WORD_W  = 2 * LANE_W;
    localparam int N_COPY  = LANE_W / 32;
    localparam int N_SLICE = 2;

    logic [N_SLICE-1:0] sl_vld, sl_sop, sl_hit, sl_eq;
    lfsr_t              sl_state [N_SLICE];
    logic [LANE_W-1:0]  lane_word [N_SLICE];
    logic [LANE_W-1:0]  upper_word;
    logic [CNT_W-1:0]   cnt_q [N_SLICE][2];

    assign sl_vld = {rx_valid_b && !combined_mode, rx_valid_a};
    assign sl_sop = {rx_sop_b, rx_sop_a};

    // One generator per slice, plus its lane word.
    for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
        dic_lane_gen #(.SEED(SEED)) u_gen (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .beat_vld  (sl_vld[s]),
            .beat_sop  (sl_sop[s]),
            .hit       (sl_hit[s]),
            .exp_state (sl_state[s])
        );
        for (genvar k = 0; k < N_COPY; k++) begin : g_copy
            assign lane_word[s][k*32 +: 32] = {1'b1, sl_state[s]};
        end
    end

    // Upper half of the combined-mode word, built from the slice A state.
    for (genvar k = 0; k < N_COPY; k++) begin : g_upper
        assign upper_word[k*32 +: 32] = {1'b0, ~sl_state[0]};
    end

    // Word compare: the full bus in combined mode, each half in split mode.
    always_comb begin
        if (combined_mode) sl_eq[0] = (rx_data == {upper_word, lane_word[0]});
        else               sl_eq[0] = (rx_data[LANE_W-1:0] == lane_word[0]);
        sl_eq[1] = (rx_data[WORD_W-1:LANE_W] == lane_word[1]);
    end

    // Match (k=0) and mismatch (k=1) counters for each slice.
    for (genvar s = 0; s < N_SLICE; s++) begin : g_cnt_s
        for (genvar k = 0; k < 2; k++) begin : g_cnt_k
            dic_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (clr),
                .inc   (sl_hit[s] && (k == 0 ? sl_eq[s] : !sl_eq[s])),
                .cnt   (cnt_q[s][k])
            );
        end
    end

    assign a_match_cnt = cnt_q[0][0];
    assign a_miss_cnt  = cnt_q[0][1];
    assign b_match_cnt = cnt_q[1][0];
    assign b_miss_cnt  = cnt_q[1][1];

    // R3
    b_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (combined_mode && !clr) |=> ($stable(b_match_cnt) && $stable(b_miss_cnt)));

    // R4
    one_per_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_a && rx_sop_a && !clr && a_match_cnt != '1 && a_miss_cnt != '1)
        |=> ({1'b0, a_match_cnt} + {1'b0, a_miss_cnt})
            == $past({1'b0, a_match_cnt} + {1'b0, a_miss_cnt}) + 1'b1);
endmodule

// File: tb/tb_dic_checker.sv
`timescale 1ns/1ps
// Scoreboard bench: the step task drives one cycle and queues the expected
// counter values; the monitor pops and compares them after each edge.
module tb_dic_checker;
    localparam int CW = 8;
    localparam int CMAX = 255;
    localparam logic [30:0] SEED = 31'h1;

    logic clk = 1'b0, rst_n = 1'b0, combined_mode = 1'b0, clr = 1'b0;
    logic [319:0] rx_data = '0;
    logic rx_valid_a = 1'b0, rx_sop_a = 1'b0, rx_valid_b = 1'b0, rx_sop_b = 1'b0;
    logic [CW-1:0] a_match_cnt, a_miss_cnt, b_match_cnt, b_miss_cnt;

    always #10 clk = ~clk;

    dic_checker #(.LANE_W(160), .CNT_W(CW), .SEED(SEED)) dut (
        .clk(clk), .rst_n(rst_n), .combined_mode(combined_mode), .clr(clr),
        .rx_data(rx_data), .rx_valid_a(rx_valid_a), .rx_sop_a(rx_sop_a),
        .rx_valid_b(rx_valid_b), .rx_sop_b(rx_sop_b),
        .a_match_cnt(a_match_cnt), .a_miss_cnt(a_miss_cnt),
        .b_match_cnt(b_match_cnt), .b_miss_cnt(b_miss_cnt));

    typedef struct {
        int unsigned am, ax, bm, bx;
        string tag;
    } exp_t;

    exp_t q[$];
    int checks = 0, errors = 0;
    bit finished = 0;

    // Reference model state, built from the requirements.
    logic [30:0] st_a = SEED, st_b = SEED;
    bit al_a = 0, al_b = 0;
    int unsigned m_am = 0, m_ax = 0, m_bm = 0, m_bx = 0;

    function automatic logic [30:0] nxt(logic [30:0] s);
        return {s[29:0], s[30] ^ s[27]};
    endfunction
    function automatic logic [159:0] lane(logic [30:0] s);
        return {5{1'b1, s}};
    endfunction
    function automatic logic [159:0] upper(logic [30:0] s);
        return {5{1'b0, ~s}};
    endfunction
    function automatic int unsigned sinc(int unsigned x);
        return (x == CMAX) ? x : x + 1;
    endfunction

    task automatic cmp(string tag, string fld, int unsigned act, int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, fld, act, exp);
        end
    endtask

    // Drive one cycle and queue the expected counters after its edge.
    task automatic step(bit md, bit va, bit pa, bit vb, bit pb,
                        bit ea, bit eb, bit c, string tag);
        logic [319:0] d;
        logic [30:0] ca, cb;
        bit cnt_a, cnt_b;
        exp_t e;
        @(negedge clk);
        for (int i = 0; i < 10; i++) d[i*32 +: 32] = $urandom;
        ca = al_a ? st_a : SEED;
        cb = al_b ? st_b : SEED;
        cnt_a = !c && va && (al_a || pa);
        cnt_b = !c && !md && vb && (al_b || pb);
        if (md) begin
            if (cnt_a) d = {upper(ca), lane(ca)};
            if (ea) d[300] = ~d[300];
        end else begin
            if (cnt_a) d[159:0] = lane(ca);
            if (cnt_b) d[319:160] = lane(cb);
            if (ea) d[7] = ~d[7];
            if (eb) d[200] = ~d[200];
        end
        combined_mode = md; clr = c; rx_data = d;
        rx_valid_a = va; rx_sop_a = pa; rx_valid_b = vb; rx_sop_b = pb;
        if (c) begin
            m_am = 0; m_ax = 0; m_bm = 0; m_bx = 0; al_a = 0; al_b = 0;
        end else begin
            if (cnt_a) begin
                al_a = 1; st_a = nxt(ca);
                if (ea) m_ax = sinc(m_ax); else m_am = sinc(m_am);
            end
            if (cnt_b) begin
                al_b = 1; st_b = nxt(cb);
                if (eb) m_bx = sinc(m_bx); else m_bm = sinc(m_bm);
            end
        end
        e.am = m_am; e.ax = m_ax; e.bm = m_bm; e.bx = m_bx; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare the counters shortly after each edge.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(e.tag, "a_match", a_match_cnt, e.am);
            cmp(e.tag, "a_miss",  a_miss_cnt,  e.ax);
            cmp(e.tag, "b_match", b_match_cnt, e.bm);
            cmp(e.tag, "b_miss",  b_miss_cnt,  e.bx);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        step(0, 0, 0, 0, 0, 0, 0, 0, "R9");
        // R6 split: beats before the start flag are ignored
        for (int i = 0; i < 3; i++) step(0, 1, 0, 1, 0, 0, 0, 0, "R6");
        // R2 slice A aligns first; B still waits
        step(0, 1, 1, 1, 0, 0, 0, 0, "R2");
        for (int i = 0; i < 4; i++) step(0, 1, 0, 1, 0, 0, 0, 0, "R2");
        step(0, 1, 0, 1, 1, 0, 0, 0, "R2");
        // R4/R5 mixed errors and valid gaps per slice
        for (int i = 0; i < 20; i++)
            step(0, i % 3 != 0, 0, i % 4 != 1, 0, i % 5 == 2, i % 7 == 3, 0, "R4");
        // R5 idle cycles hold the sequence
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "R5");
        step(0, 1, 0, 1, 0, 0, 0, 0, "R5");
        // R6 a later start flag does not restart
        step(0, 1, 1, 1, 1, 0, 0, 0, "R6");
        step(0, 1, 0, 1, 0, 0, 0, 0, "R6");
        // R3 combined mode freezes B while B is driven
        for (int i = 0; i < 6; i++) step(1, 1, 0, 1, 1, 0, 1, 0, "R3");
        // R8 clear wins over a same-cycle beat
        step(1, 1, 1, 1, 1, 0, 0, 1, "R8");
        step(1, 1, 0, 0, 0, 0, 0, 0, "R8");
        // R1 combined 320-bit compare, upper-half error counts as mismatch
        step(1, 1, 1, 1, 1, 0, 0, 0, "R1");
        for (int i = 0; i < 12; i++) step(1, 1, 0, 1, 0, i % 4 == 1, 0, 0, "R1");
        step(1, 1, 1, 0, 0, 0, 0, 0, "R1");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R3");
        // R7 saturation in split mode
        step(0, 0, 0, 0, 0, 0, 0, 1, "R8");
        step(0, 1, 1, 1, 1, 0, 1, 0, "R7");
        for (int i = 0; i < 300; i++) step(0, 1, 0, 1, 0, 0, 1, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R8");
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #4000000;
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule